// File: doc/BRIEF.md
# Hashed inverted page table lookup

This block turns a virtual address into a physical address using a table that is sized by physical page frames, not by virtual pages. The virtual page number is folded through an XOR hash, and the result picks one table entry. The entry holds the tag of the virtual page it currently describes, the frame number of that page, a residency flag and an occupancy flag. The stored tag is compared with the requested page number. The outcome is reported one of three ways: a hit with a physical address, a page fault for a known page that is not in memory, or a miss that tells the requester to fall back to the full page table.

Software or a refill engine fills the table through a write port. Each write replaces one whole entry in a single cycle. A requester pulses a strobe together with the virtual address and gets a registered answer on the following cycle. The block keeps no chaining: two pages that hash to the same entry cannot both be present, and the one not stored reads as a miss.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is low. Every table entry is empty, so any lookup made before a refill reports a miss.
- R2: The table index is formed from x = vpn[19:10] XOR vpn[9:0], where vpn is `req_vaddr[31:12]`. The index is x[5:0] XOR {2'b00, x[9:6]}.
- R3: An entry is a hit when it is occupied, its tag equals the vpn and its residency flag is set. The result is status 2'b01 with `rsp_paddr` = {stored frame, `req_vaddr[11:0]`}.
- R4: An entry is a page fault when it is occupied and its tag equals the vpn but its residency flag is clear. The result is status 2'b10 with `rsp_paddr` = 0.
- R5: A lookup is a miss when the selected entry is empty or its tag differs from the vpn. The result is status 2'b11 with `rsp_paddr` = 0.
- R6: `rsp_valid` rises exactly one cycle after each `req_valid` cycle and is low otherwise. When `rsp_valid` is low, status is 2'b00 and `rsp_paddr` is 0.
- R7: A write with `wr_en` high stores tag, frame and residency at `wr_idx` and marks the entry occupied. Lookups from the next cycle onward see the new contents. A lookup in the same cycle as the write sees the previous contents.
- R8: A write changes only the entry at `wr_idx`. A later write to the same index replaces all of that entry's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address: page number above, offset in the low 12 bits |
| wr_en | input | 1 | Refill write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 20 | Virtual page tag to store |
| wr_pfn | input | 16 | Physical frame number to store |
| wr_resident | input | 1 | Residency flag to store |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_status | output | 2 | 00 idle, 01 hit, 10 page fault, 11 miss |
| rsp_paddr | output | 28 | Physical address on a hit, zero otherwise |

## Verification
The hardest case to reach from the ports is a true tag mismatch: an occupied entry that belongs to a different page with the same hash. Random addresses almost never collide. The bench therefore builds an alias of a stored page by flipping the same bit in both halves of its page number, which leaves the hash unchanged, and looks that alias up. Random traffic draws from a small pool of pages that includes such aliases. It also places writes in the same cycle as lookups of the same entry, so the ordering between the old and new contents is exercised.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int DEF_VPN_W  = 20;
    localparam int DEF_OFF_W  = 12;
    localparam int DEF_FRAMES = 64;
    localparam int DEF_PFN_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HIT   = 2'b01,
        ST_FAULT = 2'b10,
        ST_MISS  = 2'b11
    } xlat_status_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int VPN_W = ipt_pkg::DEF_VPN_W,
    parameter int IDX_W = 6
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int HALF_W = VPN_W / 2;

    logic [HALF_W-1:0] folded;

    assign folded = vpn[VPN_W-1 -: HALF_W] ^ vpn[HALF_W-1:0];

    always_comb begin
        idx = '0;
        for (int i = 0; i < HALF_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ folded[i];
        end
    end
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
    parameter int VPN_W  = ipt_pkg::DEF_VPN_W,
    parameter int PFN_W  = ipt_pkg::DEF_PFN_W,
    parameter int FRAMES = ipt_pkg::DEF_FRAMES,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_resident,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    output logic             rd_resident,
    output logic [VPN_W-1:0] rd_tag,
    output logic [PFN_W-1:0] rd_pfn
);
    typedef struct packed {
        logic             used;
        logic             resident;
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
    } slot_t;

    slot_t slots [FRAMES];

    for (genvar g = 0; g < FRAMES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g].used     <= 1'b1;
                slots[g].resident <= wr_resident;
                slots[g].tag      <= wr_tag;
                slots[g].pfn      <= wr_pfn;
            end
        end
    end

    slot_t sel;
    assign sel         = slots[rd_idx];
    assign rd_used     = sel.used;
    assign rd_resident = sel.resident;
    assign rd_tag      = sel.tag;
    assign rd_pfn      = sel.pfn;
endmodule

// File: rtl/ipt_judge.sv
module ipt_judge #(
    parameter int VPN_W = ipt_pkg::DEF_VPN_W,
    parameter int OFF_W = ipt_pkg::DEF_OFF_W,
    parameter int PFN_W = ipt_pkg::DEF_PFN_W,
    localparam int PA_W = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    input  logic             ent_used,
    input  logic             ent_resident,
    input  logic [VPN_W-1:0] ent_tag,
    input  logic [PFN_W-1:0] ent_pfn,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [PA_W-1:0]  rsp_paddr
);
    import ipt_pkg::*;

    xlat_status_e verdict;
    logic         tag_eq;

    assign tag_eq = ent_used && (ent_tag == req_vpn);

    always_comb begin
        if (!tag_eq)
            verdict = ST_MISS;
        else if (ent_resident)
            verdict = ST_HIT;
        else
            verdict = ST_FAULT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_IDLE;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_status <= verdict;
                rsp_paddr  <= (verdict == ST_HIT) ? {ent_pfn, req_off} : '0;
            end else begin
                rsp_status <= ST_IDLE;
                rsp_paddr  <= '0;
            end
        end
    end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int VPN_W  = ipt_pkg::DEF_VPN_W,
    parameter int OFF_W  = ipt_pkg::DEF_OFF_W,
    parameter int PFN_W  = ipt_pkg::DEF_PFN_W,
    parameter int FRAMES = ipt_pkg::DEF_FRAMES,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_resident,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [PA_W-1:0]  rsp_paddr
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] idx;
    logic             e_used, e_res;
    logic [VPN_W-1:0] e_tag;
    logic [PFN_W-1:0] e_pfn;

    assign vpn = req_vaddr[VA_W-1:OFF_W];
    assign off = req_vaddr[OFF_W-1:0];

    ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
        .vpn (vpn),
        .idx (idx)
    );

    ipt_store #(.VPN_W(VPN_W), .PFN_W(PFN_W), .FRAMES(FRAMES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_tag      (wr_tag),
        .wr_pfn      (wr_pfn),
        .wr_resident (wr_resident),
        .rd_idx      (idx),
        .rd_used     (e_used),
        .rd_resident (e_res),
        .rd_tag      (e_tag),
        .rd_pfn      (e_pfn)
    );

    ipt_judge #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_judge (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_vpn      (vpn),
        .req_off      (off),
        .ent_used     (e_used),
        .ent_resident (e_res),
        .ent_tag      (e_tag),
        .ent_pfn      (e_pfn),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .rsp_paddr    (rsp_paddr)
    );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int OFF_W = 12,
    parameter int VA_W  = 32,
    parameter int PA_W  = 28
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [1:0]      rsp_status,
    input logic [PA_W-1:0] rsp_paddr
);
    // R6: a response follows every strobe
    a_r6_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R6: no response without a strobe
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R6: idle outputs are quiet
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_status == 2'b00 && rsp_paddr == '0));

    // R1: nothing reported in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rsp_valid);

    // R3: the page offset passes through on a hit
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_status != 2'b01 ||
                       rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R4 and R5: non-hit results carry no address
    a_r5_nonhit_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'b01) |-> rsp_paddr == '0);

    // R6: a valid response never shows the idle code
    a_r6_valid_coded: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_status != 2'b00);
endmodule

bind ipt_lookup ipt_lookup_chk #(.OFF_W(OFF_W), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_paddr  (rsp_paddr)
);

// File: tb/sim_ipt_lookup.sv
`timescale 1ns/1ps
module sim_ipt_lookup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_tag = '0;
    logic [15:0] wr_pfn = '0;
    logic        wr_resident = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [27:0] rsp_paddr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          m_used [64];
    bit          m_res  [64];
    logic [19:0] m_tag  [64];
    logic [15:0] m_pfn  [64];
    logic [19:0] pool   [16];

    always #10 clk = ~clk;

    ipt_lookup u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_pfn(wr_pfn),
        .wr_resident(wr_resident), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    // R2: folded XOR hash
    function automatic logic [5:0] hash_of(input logic [19:0] v);
        logic [9:0] x;
        x = v[19:10] ^ v[9:0];
        return x[5:0] ^ {2'b00, x[9:6]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge, check the result at the next negedge
    task automatic step(input bit rq, input logic [31:0] va, input bit we,
                        input logic [5:0] wi, input logic [19:0] wt,
                        input logic [15:0] wp, input bit wr, input string req);
        logic [1:0]  es;
        logic [27:0] ep;
        logic [5:0]  h;
        req_valid = rq; req_vaddr = va;
        wr_en = we; wr_idx = wi; wr_tag = wt; wr_pfn = wp; wr_resident = wr;
        h = hash_of(va[31:12]);
        es = 2'b00; ep = '0;
        if (rq) begin
            if (!m_used[h] || m_tag[h] != va[31:12]) es = 2'b11;
            else if (m_res[h]) begin es = 2'b01; ep = {m_pfn[h], va[11:0]}; end
            else es = 2'b10;
        end
        if (we) begin
            m_used[wi] = 1'b1; m_res[wi] = wr; m_tag[wi] = wt; m_pfn[wi] = wp;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, 32'(rsp_valid), 32'(rq));
        check({req, " status"}, 32'(rsp_status), 32'(es));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ep));
    endtask

    task automatic put(input logic [19:0] v, input logic [15:0] p, input bit r, input string req);
        step(0, '0, 1, hash_of(v), v, p, r, req);
    endtask

    task automatic look(input logic [19:0] v, input logic [11:0] o, input string req);
        step(1, {v, o}, 0, '0, '0, '0, 0, req);
    endtask

    initial begin
        void'($urandom(32'h1d5));
        for (int i = 0; i < 64; i++) begin
            m_used[i] = 0; m_res[i] = 0; m_tag[i] = '0; m_pfn[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset valid", 32'(rsp_valid), 0);
        look(20'h00000, 12'h000, "R1 empty lookup");
        look(20'hfffff, 12'h3a5, "R1 empty lookup high");

        // R3 hit and R2 hash placement
        put(20'h12345, 16'hbeef, 1, "R7 write");
        look(20'h12345, 12'h7c1, "R3 hit");
        look(20'h12345, 12'hfff, "R3 hit offset max");
        // R5 alias with the same hash, different tag
        look(20'h12345 ^ 20'h00401, 12'h010, "R5 alias miss");
        // R4 fault
        put(20'h0a0b0, 16'h0042, 0, "R7 write");
        look(20'h0a0b0, 12'h123, "R4 fault");
        // R8 overwrite makes it resident with a new frame
        put(20'h0a0b0, 16'h9999, 1, "R8 overwrite");
        look(20'h0a0b0, 12'h456, "R8 overwrite hit");
        look(20'h12345, 12'h001, "R8 neighbour intact");
        // R8 replace by alias evicts the old page
        put(20'h12345 ^ 20'h00401, 16'h0001, 1, "R8 replace");
        look(20'h12345, 12'h002, "R8 evicted miss");
        look(20'h12345 ^ 20'h00401, 12'h003, "R8 replaced hit");
        // R2 highest index: x = 0x03f gives index 63
        put(20'h0003f, 16'hffff, 1, "R2 write top");
        look(20'h0003f, 12'h800, "R2 top index hit");
        // R7 write and lookup of the same entry in one cycle
        step(1, {20'h55555, 12'h0aa}, 1, hash_of(20'h55555), 20'h55555, 16'h1234, 1, "R7 same cycle");
        look(20'h55555, 12'h0ab, "R7 next cycle");
        // R6 idle
        step(0, 32'hdeadbeef, 0, '0, '0, '0, 0, "R6 idle");

        for (int i = 0; i < 16; i++) begin
            pool[i] = 20'($urandom);
            if (i % 4 == 3) pool[i] = pool[i-1] ^ 20'h00802;
        end
        for (int n = 0; n < 600; n++) begin
            logic [19:0] v, w;
            bit rq, we;
            int sel;
            v = pool[$urandom_range(15)];
            w = pool[$urandom_range(15)];
            sel = $urandom_range(9);
            rq = (sel != 0);
            we = ($urandom_range(3) == 0);
            step(rq, {v, 12'($urandom)}, we, hash_of(w), w, 16'($urandom),
                 bit'($urandom_range(3) != 0), "R3 R4 R5 random");
        end
        step(0, '0, 0, '0, '0, '0, 0, "R6 final idle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule